// File: doc/BRIEF.md
# E3 Maintenance Byte Monitor

This block watches the maintenance-and-adaptation byte that an upstream E3 framer pulls out of each received frame in the G.832 format. A one-cycle frame strobe marks the cycles on which the byte is valid. The block filters the far-end receive failure (FERF) indication that the byte carries. The filtered state only changes once the same indication has been seen in a programmable number of consecutive frames. The host picks the persistence length: three frames for the short setting and five for the long one.

The same byte carries a 3-bit payload type. The block captures it from every frame and compares it with an expected value set by the host. On the frame where the two first disagree, it emits a one-cycle interrupt pulse. The persistence select and the expected type are registered inside the block. They are returned to the host, together with the received payload type, on a single status word.

The FERF indication is bit 7 of the byte. The far-end block error indication is bit 6 and is not used here. The payload type is bits 5:3.

Top module: `e3_maint_monitor`

## Requirements
- R1: While reset is active, and on the first cycles after it, `ferf_state`, `rx_ptype`, `ptype_irq` and `cfg_status` are all zero.
- R2: With the persistence select registered at 0, `ferf_state` goes to 1 after the clock edge that samples the third consecutive strobed frame whose bit 7 is 1.
- R3: With the persistence select registered at 0, `ferf_state` goes to 0 after the edge that samples the third consecutive strobed frame whose bit 7 is 0.
- R4: With the persistence select registered at 1, declaring and clearing each need five consecutive strobed frames with the same bit 7 value.
- R5: A strobed frame whose bit 7 differs from the current run starts a new run of length 1. The run length saturates at five. Cycles without a strobe leave the run and `ferf_state` unchanged, whatever the byte holds.
- R6: `rx_ptype` takes bits 5:3 of the byte at every strobe and holds that value until the next strobe.
- R7: `ptype_irq` is high for exactly one cycle, after the edge of a strobe whose bits 5:3 differ from the registered expected type, and only if the previous strobed frame matched (or no frame has been seen since reset). While a mismatch persists, no further pulse is issued.
- R8: `persist_long` and `exp_ptype` are captured every clock. `cfg_status` reads {1'b0, expected type [6:4], persistence select [3], rx_ptype [2:0]}.
- R9: A strobe is judged against the persistence select and expected type that were registered on the edge before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| frame_stb | input | 1 | Marks the cycle on which `maint_byte` is valid |
| maint_byte | input | 8 | Maintenance-and-adaptation byte of the current frame |
| persist_long | input | 1 | 0: three-frame persistence, 1: five-frame persistence |
| exp_ptype | input | 3 | Expected payload type |
| ferf_state | output | 1 | Filtered far-end receive failure state |
| rx_ptype | output | 3 | Payload type of the latest frame |
| ptype_irq | output | 1 | One-cycle payload type mismatch pulse |
| cfg_status | output | 8 | Configuration and status read-back word |

## Verification
A single strobe can complete a FERF run and also turn the payload comparison from match to mismatch. When that happens, `ferf_state` and `ptype_irq` must both change after the same edge. The bench provokes this directly: the frame that completes a run also carries a new, unexpected payload type. The random phase keeps long runs of equal bit 7 values and mixes in occasional payload changes, so the two events meet again and again. On every cycle, both outputs and the read-back word are compared with the bench's model. Changes to the configuration land in the cycle just before a strobe, which exercises the one-cycle capture rule.

// File: rtl/e3mm_pkg.sv
package e3mm_pkg;
  // Field positions inside the maintenance byte
  localparam int unsigned FERF_BIT = 7;
  localparam int unsigned PT_HI    = 5;
  localparam int unsigned PT_LO    = 3;
  localparam int unsigned PT_W     = PT_HI - PT_LO + 1;

  // Comparison state of the payload type checker
  typedef enum logic {
    PT_MATCH    = 1'b0,
    PT_MISMATCH = 1'b1
  } pt_cmp_e;
endpackage

// File: rtl/e3mm_rst_sync.sv
module e3mm_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/e3mm_cfg_reg.sv
module e3mm_cfg_reg #(
  parameter int unsigned PT_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            persist_long,
  input  logic [PT_W-1:0] exp_ptype,
  output logic            sel_q,
  output logic [PT_W-1:0] exp_q
);
  logic            cap_en;
  logic            sel_d;
  logic [PT_W-1:0] exp_d;

  assign cap_en = 1'b1;

  always_comb begin
    sel_d = sel_q;
    exp_d = exp_q;
    if (cap_en) begin
      sel_d = persist_long;
      exp_d = exp_ptype;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= 1'b0;
      exp_q <= '0;
    end else begin
      sel_q <= sel_d;
      exp_q <= exp_d;
    end
  end
endmodule

// File: rtl/e3mm_persist.sv
module e3mm_persist #(
  parameter int unsigned SHORT_RUN = 3,
  parameter int unsigned LONG_RUN  = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stb,
  input  logic ind_bit,
  input  logic sel_long,
  output logic state_q
);
  localparam int unsigned CNT_W = $clog2(LONG_RUN + 1);
  localparam logic [CNT_W-1:0] SHORT_LIM = CNT_W'(SHORT_RUN);
  localparam logic [CNT_W-1:0] LONG_LIM  = CNT_W'(LONG_RUN);
  localparam logic [CNT_W-1:0] ONE       = CNT_W'(1);

  logic             run_q, run_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             state_d;
  logic [CNT_W-1:0] limit;

  assign limit = sel_long ? LONG_LIM : SHORT_LIM;

  always_comb begin
    run_d   = run_q;
    cnt_d   = cnt_q;
    state_d = state_q;
    if (stb) begin
      if (ind_bit == run_q) begin
        if (cnt_q < LONG_LIM) cnt_d = cnt_q + ONE;
      end else begin
        run_d = ind_bit;
        cnt_d = ONE;
      end
      if ((cnt_d >= limit) && (run_d != state_q)) state_d = run_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      cnt_q   <= '0;
      state_q <= 1'b0;
    end else begin
      run_q   <= run_d;
      cnt_q   <= cnt_d;
      state_q <= state_d;
    end
  end
endmodule

// File: rtl/e3mm_ptype_chk.sv
module e3mm_ptype_chk
  import e3mm_pkg::*;
#(
  parameter int unsigned W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         stb,
  input  logic [W-1:0] pt_in,
  input  logic [W-1:0] pt_exp,
  output logic [W-1:0] pt_q,
  output logic         irq_q
);
  pt_cmp_e      cmp_q, cmp_d;
  logic [W-1:0] pt_d;
  logic         irq_d;

  always_comb begin
    pt_d  = pt_q;
    cmp_d = cmp_q;
    irq_d = 1'b0;
    if (stb) begin
      pt_d  = pt_in;
      cmp_d = (pt_in != pt_exp) ? PT_MISMATCH : PT_MATCH;
      irq_d = (cmp_d == PT_MISMATCH) && (cmp_q == PT_MATCH);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pt_q  <= '0;
      cmp_q <= PT_MATCH;
      irq_q <= 1'b0;
    end else begin
      pt_q  <= pt_d;
      cmp_q <= cmp_d;
      irq_q <= irq_d;
    end
  end
endmodule

// File: rtl/e3_maint_monitor.sv
module e3_maint_monitor
  import e3mm_pkg::*;
#(
  parameter int unsigned SHORT_RUN = 3,
  parameter int unsigned LONG_RUN  = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            frame_stb,
  input  logic [7:0]      maint_byte,
  input  logic            persist_long,
  input  logic [PT_W-1:0] exp_ptype,
  output logic            ferf_state,
  output logic [PT_W-1:0] rx_ptype,
  output logic            ptype_irq,
  output logic [7:0]      cfg_status
);
  logic            rst_n_sync;
  logic            sel_q;
  logic [PT_W-1:0] exp_q;

  e3mm_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  e3mm_cfg_reg #(.PT_W(PT_W)) u_cfg (
    .clk          (clk),
    .rst_n        (rst_n_sync),
    .persist_long (persist_long),
    .exp_ptype    (exp_ptype),
    .sel_q        (sel_q),
    .exp_q        (exp_q)
  );

  e3mm_persist #(.SHORT_RUN(SHORT_RUN), .LONG_RUN(LONG_RUN)) u_ferf (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .stb      (frame_stb),
    .ind_bit  (maint_byte[FERF_BIT]),
    .sel_long (sel_q),
    .state_q  (ferf_state)
  );

  e3mm_ptype_chk #(.W(PT_W)) u_pt (
    .clk    (clk),
    .rst_n  (rst_n_sync),
    .stb    (frame_stb),
    .pt_in  (maint_byte[PT_HI:PT_LO]),
    .pt_exp (exp_q),
    .pt_q   (rx_ptype),
    .irq_q  (ptype_irq)
  );

  assign cfg_status = {1'b0, exp_q, sel_q, rx_ptype};
endmodule

// File: rtl/e3mm_checker.sv
module e3mm_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       frame_stb,
  input logic [7:0] maint_byte,
  input logic       ferf_state,
  input logic [2:0] rx_ptype,
  input logic       ptype_irq
);
  // R7: the interrupt never lasts two cycles
  p_irq_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ptype_irq |=> !ptype_irq);

  // R7: a pulse only follows a strobe
  p_irq_after_stb_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ptype_irq) |-> $past(frame_stb));

  // R6: the payload type holds between strobes
  p_ptype_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_stb |=> $stable(rx_ptype));

  // R6: the payload type loads from bits 5:3
  p_ptype_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_stb |=> (rx_ptype == $past(maint_byte[5:3])));

  // R5: no strobe, no change of the FERF state
  p_ferf_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_stb |=> $stable(ferf_state));

  // R2: declaration only on a frame carrying bit 7 = 1
  p_ferf_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ferf_state) |-> $past(maint_byte[7]));

  // R3: clearing only on a frame carrying bit 7 = 0
  p_ferf_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ferf_state) |-> !$past(maint_byte[7]));
endmodule

bind e3_maint_monitor e3mm_checker chk_i (
  .clk        (clk),
  .rst_n      (rst_n_sync),
  .frame_stb  (frame_stb),
  .maint_byte (maint_byte),
  .ferf_state (ferf_state),
  .rx_ptype   (rx_ptype),
  .ptype_irq  (ptype_irq)
);

// File: tb/e3_maint_monitor_tb.sv
`timescale 1ns/1ps
module e3_maint_monitor_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       frame_stb;
  logic [7:0] maint_byte;
  logic       persist_long;
  logic [2:0] exp_ptype;
  logic       ferf_state;
  logic [2:0] rx_ptype;
  logic       ptype_irq;
  logic [7:0] cfg_status;

  int n_chk = 0;
  int n_bad = 0;

  // bench model
  logic       m_sel, m_run, m_ferf, m_mis, m_irq;
  logic [2:0] m_exp, m_pt;
  int         m_cnt;

  always #4 clk = ~clk;

  e3_maint_monitor dut_i (
    .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .maint_byte(maint_byte),
    .persist_long(persist_long), .exp_ptype(exp_ptype),
    .ferf_state(ferf_state), .rx_ptype(rx_ptype), .ptype_irq(ptype_irq),
    .cfg_status(cfg_status)
  );

  function automatic int limit_of(input logic sel);
    return sel ? 5 : 3;
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_sel = 0; m_exp = 0; m_run = 0; m_cnt = 0; m_ferf = 0;
    m_pt = 0; m_mis = 0; m_irq = 0;
  endtask

  task automatic model_edge(input logic stb, input logic [7:0] b,
                            input logic sel, input logic [2:0] ex);
    logic nm;
    m_irq = 0;
    if (stb) begin
      if (b[7] == m_run) begin
        if (m_cnt < 5) m_cnt++;
      end else begin
        m_run = b[7];
        m_cnt = 1;
      end
      if (m_cnt >= limit_of(m_sel)) m_ferf = m_run;
      m_pt  = b[5:3];
      nm    = (b[5:3] != m_exp);
      m_irq = nm && !m_mis;
      m_mis = nm;
    end
    m_sel = sel;
    m_exp = ex;
  endtask

  task automatic step(input logic stb, input logic [7:0] b, input logic sel,
                      input logic [2:0] ex, input string tag);
    @(negedge clk);
    frame_stb = stb; maint_byte = b; persist_long = sel; exp_ptype = ex;
    @(posedge clk);
    model_edge(stb, b, sel, ex);
    #2;
    check(tag, {7'd0, ferf_state}, {7'd0, m_ferf});
    check("R6", {5'd0, rx_ptype}, {5'd0, m_pt});
    check("R7", {7'd0, ptype_irq}, {7'd0, m_irq});
    check("R8", cfg_status, {1'b0, m_exp, m_sel, m_pt});
  endtask

  function automatic logic [7:0] mk(input logic f, input logic [2:0] pt);
    return {f, 1'b0, pt, 3'b101};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 0; frame_stb = 0; maint_byte = 8'hFF; persist_long = 0; exp_ptype = 0;
    model_reset();
    repeat (3) @(posedge clk);
    #2;
    check("R1", {ferf_state, ptype_irq, 3'd0, rx_ptype}, 8'd0);
    check("R1", cfg_status, 8'd0);
    @(negedge clk); rst_n = 1;
    // idle while the reset synchronizer releases; bench drives nothing new
    repeat (3) step(0, 8'h00, 0, 3'd0, "R1");

    // R2: three frames with bit 7 = 1 at short persistence
    step(1, mk(1, 0), 0, 0, "R2");
    step(0, 8'h00, 0, 0, "R5");          // non-strobe garbage ignored
    step(1, mk(1, 0), 0, 0, "R2");
    check("R2", {7'd0, ferf_state}, 8'd0);
    step(1, mk(1, 0), 0, 0, "R2");
    check("R2", {7'd0, ferf_state}, 8'd1);

    // R5: a break restarts the run
    step(1, mk(0, 0), 0, 0, "R5");
    step(1, mk(0, 0), 0, 0, "R5");
    step(1, mk(1, 0), 0, 0, "R5");
    step(1, mk(0, 0), 0, 0, "R5");
    step(0, 8'h80, 0, 0, "R5");
    step(1, mk(0, 0), 0, 0, "R5");
    check("R5", {7'd0, ferf_state}, 8'd1);
    // R3: third zero clears
    step(1, mk(0, 0), 0, 0, "R3");
    check("R3", {7'd0, ferf_state}, 8'd0);

    // R4/R9: long persistence, selected a cycle ahead
    step(0, 8'h00, 1, 0, "R9");
    for (int i = 0; i < 4; i++) step(1, mk(1, 0), 1, 0, "R4");
    check("R4", {7'd0, ferf_state}, 8'd0);
    step(1, mk(1, 0), 1, 0, "R4");
    check("R4", {7'd0, ferf_state}, 8'd1);
    for (int i = 0; i < 4; i++) step(1, mk(0, 0), 1, 0, "R4");
    check("R4", {7'd0, ferf_state}, 8'd1);

    // FERF clear and mismatch on the same strobe (R4 and R7)
    step(1, mk(0, 3'd6), 1, 0, "R4");
    check("R4", {7'd0, ferf_state}, 8'd0);
    check("R7", {7'd0, ptype_irq}, 8'd1);
    step(1, mk(0, 3'd2), 1, 0, "R7");    // still mismatching: no pulse
    check("R7", {7'd0, ptype_irq}, 8'd0);
    step(0, 8'h00, 1, 3'd2, "R9");       // expected type now matches
    step(1, mk(0, 3'd2), 1, 3'd2, "R7");
    step(1, mk(0, 3'd7), 1, 3'd2, "R7");
    check("R7", {7'd0, ptype_irq}, 8'd1);

    // random phase
    begin
      logic f = 0;
      logic s = 0;
      logic [2:0] e = 3'd2;
      logic [2:0] p = 3'd2;
      for (int i = 0; i < 4000; i++) begin
        if ($urandom % 8 == 0) f = ~f;
        if ($urandom % 64 == 0) s = ~s;
        if ($urandom % 48 == 0) e = 3'($urandom);
        if ($urandom % 6 == 0) p = ($urandom % 2) ? e : 3'($urandom);
        step(($urandom % 3) != 0, {f, 1'($urandom), p, 3'($urandom)}, s, e, "R5");
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule